// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides how the digital PLL of a telecom timing card sources its output frequency. Two select pins pick Normal, Holdover or Freerun. A reference-valid flag from an external validity detector can move the loop between Normal and an automatic holdover state with no pin change. The controller tells the loop which source to use: track the reference, replay a stored frequency word, or run from the master oscillator. It also drives the enable for the time-interval-error (TIE) control block, a fast-lock flag and a locking flag.

The reference-valid flag is asynchronous to the controller clock. It passes through a two-flop synchronizer that resets to "valid". A change on the flag therefore reaches the mode register on the third rising edge after it is applied. Changes on the select pins are registered on the next edge.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is low the controller is in an initial state: all status flags are low, the TIE enable and the locking flag are low, and the source code is 10. On the first clock edge after reset is released, it enters the mode given by the select pins.
- R2: In Normal with select pins 00, a low reference-valid input moves the controller to automatic holdover on the third rising edge after the input falls.
- R3: In automatic holdover with select pins 00, a high reference-valid input returns the controller to Normal on the third rising edge after the input rises.
- R4: On the transitions Normal to automatic holdover, automatic holdover to Normal, and pin-selected Holdover to Normal, the TIE enable takes the level of the TIE pin.
- R5: The normal flag is high only in Normal. The holdover flag is high in pin-selected Holdover and in automatic holdover. The freerun flag is high only in Freerun. The auto-holdover flag is high only in automatic holdover.
- R6: The fast-lock output equals the fast-lock request while the mode is Normal and is low in every other mode.
- R7: Select pins 00 mean Normal, 01 mean Holdover, and 10 and 11 mean Freerun. A pin change takes effect on the next edge. A pin choice of Holdover or Freerun takes priority over reference validity.
- R8: In pin-selected Holdover and in Freerun, the reference-valid input has no effect on the mode.
- R9: The locking flag goes high when Normal is entered straight from reset. It clears on the edge that sees the lock indication high, or when Normal is left. It is never set on any other entry into Normal.
- R10: On every other mode change, the TIE enable is forced. It is cleared on entry to Holdover or Freerun. It is set on entry to Normal from Freerun or from the initial state.
- R11: The source code is 00 (track reference) in Normal, 01 (replay stored frequency) in either holdover, and 10 (master oscillator) in Freerun and in the initial state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Mode select pins |
| ref_valid_async | input | 1 | Reference within capture range, asynchronous |
| tie_pin | input | 1 | TIE enable level used on the pin-following transitions |
| fast_lock_req | input | 1 | Fast-lock request |
| lock_ind | input | 1 | Loop reports phase lock |
| st_normal | output | 1 | Mode is Normal |
| st_holdover | output | 1 | Mode is Holdover or automatic holdover |
| st_freerun | output | 1 | Mode is Freerun |
| auto_hold | output | 1 | Mode is automatic holdover |
| tie_en | output | 1 | TIE control block enable |
| fast_lock | output | 1 | Fast-lock submode active |
| locking | output | 1 | Waiting for first lock after reset |
| src_sel | output | 2 | Loop frequency source: 00 track, 01 replay, 10 oscillator |

## Verification
Each mode decodes to its own pattern of status flags and source code. A wrong mode register therefore shows up at the ports on the edge it goes wrong. A wrong TIE value or a wrong locking value is held until the next mode change, so a single sample after each transition exposes it. Synchronizer latency is checked edge by edge: a stage too few or too many moves the automatic holdover entry or exit by one cycle. The bench checks the mode on every edge around that change.

// File: rtl/dpll_mode_pkg.sv
`timescale 1ns/1ps
package dpll_mode_pkg;

  typedef enum logic [2:0] {
    ST_INIT      = 3'd0,
    ST_NORMAL    = 3'd1,
    ST_AUTO_HOLD = 3'd2,
    ST_HOLD      = 3'd3,
    ST_FREE      = 3'd4
  } mode_t;

  localparam logic [1:0] SRC_TRACK  = 2'b00;
  localparam logic [1:0] SRC_REPLAY = 2'b01;
  localparam logic [1:0] SRC_OSC    = 2'b10;

  // select pin decode: 00 normal, 01 holdover, 1x freerun
  function automatic mode_t pin_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   pin_mode = ST_NORMAL;
      2'b01:   pin_mode = ST_HOLD;
      default: pin_mode = ST_FREE;
    endcase
  endfunction

endpackage

// File: rtl/ref_sync.sv
`timescale 1ns/1ps
module ref_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mode_fsm.sv
`timescale 1ns/1ps
module mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_ok,
  input  logic       tie_pin,
  input  logic       lock_ind,
  output mode_t      mode_q,
  output logic       tie_q,
  output logic       locking_q
);
  mode_t pin_m;
  mode_t mode_d;
  logic  mode_chg;
  logic  pin_follow;
  logic  tie_d;
  logic  locking_d;

  always_comb begin
    pin_m  = pin_mode(mode_sel);
    mode_d = mode_q;
    case (mode_q)
      ST_INIT:      mode_d = pin_m;
      ST_NORMAL: begin
        if (pin_m != ST_NORMAL) mode_d = pin_m;
        else if (!ref_ok)       mode_d = ST_AUTO_HOLD;
      end
      ST_AUTO_HOLD: begin
        if (pin_m != ST_NORMAL) mode_d = pin_m;
        else if (ref_ok)        mode_d = ST_NORMAL;
      end
      ST_HOLD, ST_FREE: mode_d = pin_m;
      default:          mode_d = ST_INIT;
    endcase
  end

  always_comb begin
    mode_chg   = (mode_d != mode_q);
    pin_follow = ((mode_q == ST_NORMAL)    && (mode_d == ST_AUTO_HOLD)) ||
                 ((mode_q == ST_AUTO_HOLD) && (mode_d == ST_NORMAL))    ||
                 ((mode_q == ST_HOLD)      && (mode_d == ST_NORMAL));
    if (pin_follow)                tie_d = tie_pin;
    else if (mode_d == ST_NORMAL)  tie_d = 1'b1;
    else                           tie_d = 1'b0;
  end

  always_comb begin
    locking_d = 1'b0;
    if ((mode_q == ST_INIT) && (mode_d == ST_NORMAL))
      locking_d = 1'b1;
    else if ((mode_q == ST_NORMAL) && (mode_d == ST_NORMAL) && locking_q && !lock_ind)
      locking_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ST_INIT;
      tie_q  <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= mode_d;
      tie_q  <= tie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locking_q <= 1'b0;
    else        locking_q <= locking_d;
  end

  // R2
  auto_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ST_NORMAL && !ref_ok && mode_sel == 2'b00) |=> (mode_q == ST_AUTO_HOLD));

  // R4
  tie_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ST_NORMAL && !ref_ok && mode_sel == 2'b00) |=> (tie_q == $past(tie_pin)));

  // R10
  tie_free_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != ST_FREE && mode_sel[1]) |=> !tie_q);

  // R8
  hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ST_HOLD && mode_sel == 2'b01) |=> (mode_q == ST_HOLD));

  // R9
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locking_q && lock_ind) |=> !locking_q);
endmodule

// File: rtl/mode_decode.sv
`timescale 1ns/1ps
module mode_decode
  import dpll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_t      mode_q,
  input  logic       fast_lock_req,
  output logic       st_normal,
  output logic       st_holdover,
  output logic       st_freerun,
  output logic       auto_hold,
  output logic       fast_lock,
  output logic [1:0] src_sel
);
  always_comb begin
    st_normal   = 1'b0;
    st_holdover = 1'b0;
    st_freerun  = 1'b0;
    auto_hold   = 1'b0;
    src_sel     = SRC_OSC;
    case (mode_q)
      ST_NORMAL: begin
        st_normal = 1'b1;
        src_sel   = SRC_TRACK;
      end
      ST_AUTO_HOLD: begin
        st_holdover = 1'b1;
        auto_hold   = 1'b1;
        src_sel     = SRC_REPLAY;
      end
      ST_HOLD: begin
        st_holdover = 1'b1;
        src_sel     = SRC_REPLAY;
      end
      ST_FREE: st_freerun = 1'b1;
      default: src_sel = SRC_OSC;
    endcase
    fast_lock = st_normal & fast_lock_req;
  end

  // R5
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_normal, st_holdover, st_freerun}));

  // R6
  fast_lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_lock |-> (st_normal && src_sel == SRC_TRACK));
endmodule

// File: rtl/dpll_mode_ctrl.sv
`timescale 1ns/1ps
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_valid_async,
  input  logic       tie_pin,
  input  logic       fast_lock_req,
  input  logic       lock_ind,
  output logic       st_normal,
  output logic       st_holdover,
  output logic       st_freerun,
  output logic       auto_hold,
  output logic       tie_en,
  output logic       fast_lock,
  output logic       locking,
  output logic [1:0] src_sel
);
  logic  ref_ok;
  mode_t mode_q;

  ref_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ref_valid_async),
    .q       (ref_ok)
  );

  mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .ref_ok    (ref_ok),
    .tie_pin   (tie_pin),
    .lock_ind  (lock_ind),
    .mode_q    (mode_q),
    .tie_q     (tie_en),
    .locking_q (locking)
  );

  mode_decode u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_q        (mode_q),
    .fast_lock_req (fast_lock_req),
    .st_normal     (st_normal),
    .st_holdover   (st_holdover),
    .st_freerun    (st_freerun),
    .auto_hold     (auto_hold),
    .fast_lock     (fast_lock),
    .src_sel       (src_sel)
  );

  // R7
  pin_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[1] |=> (st_freerun && !tie_en));
endmodule

// File: tb/dpll_mode_ctrl_tb.sv
`timescale 1ns/1ps
module dpll_mode_ctrl_tb;

  typedef struct packed {
    logic       n;
    logic       h;
    logic       f;
    logic       ah;
    logic       tie;
    logic       fl;
    logic       lk;
    logic [1:0] src;
  } exp_t;

  localparam int M_N    = 0;
  localparam int M_AH   = 1;
  localparam int M_H    = 2;
  localparam int M_F    = 3;
  localparam int M_INIT = 4;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       ref_valid_async;
  logic       tie_pin;
  logic       fast_lock_req;
  logic       lock_ind;
  logic       st_normal, st_holdover, st_freerun, auto_hold;
  logic       tie_en, fast_lock, locking;
  logic [1:0] src_sel;

  int    checks;
  int    errors;
  bit    done;
  exp_t  q_exp[$];
  string q_tag[$];

  dpll_mode_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_sel        (mode_sel),
    .ref_valid_async (ref_valid_async),
    .tie_pin         (tie_pin),
    .fast_lock_req   (fast_lock_req),
    .lock_ind        (lock_ind),
    .st_normal       (st_normal),
    .st_holdover     (st_holdover),
    .st_freerun      (st_freerun),
    .auto_hold       (auto_hold),
    .tie_en          (tie_en),
    .fast_lock       (fast_lock),
    .locking         (locking),
    .src_sel         (src_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic exp_t ex(input int m, input logic tie, input logic fl, input logic lk);
    exp_t e;
    e     = '0;
    e.tie = tie;
    e.fl  = fl;
    e.lk  = lk;
    case (m)
      M_N:  begin e.n = 1'b1; e.src = 2'b00; end
      M_AH: begin e.h = 1'b1; e.ah = 1'b1; e.src = 2'b01; end
      M_H:  begin e.h = 1'b1; e.src = 2'b01; end
      M_F:  begin e.f = 1'b1; e.src = 2'b10; end
      default: e.src = 2'b10;
    endcase
    return e;
  endfunction

  function automatic exp_t actual();
    exp_t a;
    a.n   = st_normal;
    a.h   = st_holdover;
    a.f   = st_freerun;
    a.ah  = auto_hold;
    a.tie = tie_en;
    a.fl  = fast_lock;
    a.lk  = locking;
    a.src = src_sel;
    return a;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t a;
    a = actual();
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (n h f ah tie fl lk src)", tag, a, e);
    end
  endtask

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      exp_t  e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      compare(e, t);
    end
  end

  // driver: one rising edge, push expectation, move to input slot after falling edge
  task automatic tick(input exp_t e, input string tag);
    @(posedge clk);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n           = 1'b0;
    mode_sel        = 2'b00;
    ref_valid_async = 1'b1;
    tie_pin         = 1'b0;
    fast_lock_req   = 1'b0;
    lock_ind        = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    compare(ex(M_INIT, 0, 0, 0), "R1 reset state");
    rst_n = 1'b1;

    // R1 R9 R10: Normal from reset, tie forced on, locking raised
    tick(ex(M_N, 1, 0, 1), "R1 R9 R10 enter normal");
    tick(ex(M_N, 1, 0, 1), "R9 locking held");
    fast_lock_req = 1'b1;
    tick(ex(M_N, 1, 1, 1), "R6 fast lock in normal");
    lock_ind = 1'b1;
    tick(ex(M_N, 1, 1, 0), "R9 locking cleared");
    lock_ind = 1'b0;
    fast_lock_req = 1'b0;

    // R2 R4: auto holdover on invalid reference, tie from pin (0)
    ref_valid_async = 1'b0;
    tick(ex(M_N, 1, 0, 0), "R2 sync stage 1");
    tick(ex(M_N, 1, 0, 0), "R2 sync stage 2");
    tick(ex(M_AH, 0, 0, 0), "R2 R4 R11 auto holdover");

    // R3 R4: back to normal, tie from pin (1)
    tie_pin = 1'b1;
    ref_valid_async = 1'b1;
    tick(ex(M_AH, 0, 0, 0), "R3 sync stage 1");
    tick(ex(M_AH, 0, 0, 0), "R3 sync stage 2");
    tick(ex(M_N, 1, 0, 0), "R3 R4 return normal");

    // R7 R10: pin holdover
    mode_sel = 2'b01;
    tick(ex(M_H, 0, 0, 0), "R7 R10 R5 pin holdover");
    ref_valid_async = 1'b0;
    for (int i = 0; i < 3; i++) tick(ex(M_H, 0, 0, 0), "R8 holdover ignores reference");

    // R4: holdover to normal follows pin (0)
    tie_pin = 1'b0;
    mode_sel = 2'b00;
    tick(ex(M_N, 0, 0, 0), "R4 holdover to normal tie pin");
    tie_pin = 1'b1;
    tick(ex(M_AH, 1, 0, 0), "R2 R4 auto holdover tie pin high");

    // R7: freerun pins beat invalid reference
    mode_sel = 2'b10;
    tick(ex(M_F, 0, 0, 0), "R7 R10 R11 freerun");
    ref_valid_async = 1'b1;
    tick(ex(M_F, 0, 0, 0), "R8 freerun ignores reference");
    ref_valid_async = 1'b0;
    tick(ex(M_F, 0, 0, 0), "R8 freerun ignores reference");
    ref_valid_async = 1'b1;
    tick(ex(M_F, 0, 0, 0), "R8 freerun ignores reference");
    mode_sel = 2'b11;
    tick(ex(M_F, 0, 0, 0), "R7 reserved code is freerun");
    tick(ex(M_F, 0, 0, 0), "R7 reserved code is freerun");

    // R10: freerun to normal forces tie on regardless of pin, no locking
    tie_pin = 1'b0;
    mode_sel = 2'b00;
    tick(ex(M_N, 1, 0, 0), "R10 R9 freerun to normal");
    fast_lock_req = 1'b1;
    tick(ex(M_N, 1, 1, 0), "R6 fast lock request");
    mode_sel = 2'b01;
    tick(ex(M_H, 0, 0, 0), "R6 R10 no fast lock in holdover");
    mode_sel = 2'b10;
    tick(ex(M_F, 0, 0, 0), "R6 R7 holdover to freerun");
    mode_sel = 2'b01;
    tick(ex(M_H, 0, 0, 0), "R7 freerun to holdover");
    fast_lock_req = 1'b0;

    // R1: reset with holdover selected
    rst_n = 1'b0;
    #1;
    compare(ex(M_INIT, 0, 0, 0), "R1 reset state again");
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    tick(ex(M_H, 0, 0, 0), "R1 R9 reset into holdover");

    @(negedge clk);
    #1;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL scoreboard not drained: %0d left, expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule